// File: doc/BRIEF.md
# Thread-Tagged First-Level Translation Table

This block is a small, fully associative cache of address translations that sits in front of a slower second-level translation unit in a core that runs two hardware threads. A lookup presents a 64-bit effective address and a thread number. When a valid entry with the same thread tag and the same effective page number is present, the 50-bit real address is returned in the same cycle. It is formed from the entry's real page number and the 12 untranslated page-offset bits, since pages are a fixed 4 KB.

When no entry matches, the block raises a request to the second-level unit in the same cycle. That thread is then marked as waiting, and its further lookups report not-ready until the second level answers with a fill. The fill installs the mapping. A fill goes first to the lowest-numbered empty entry. When the table is full, it goes to the entry under a round-robin pointer. A fill whose key is already present updates that entry in place. Software-style maintenance is supported by an invalidate-all input and a per-thread invalidate that removes only one thread's entries. Entries are never shared between the two threads.

Top module: `xlt_l1_table`

## Requirements
- R1: After reset no entry is valid and no thread is waiting. Every lookup reports ready and misses.
- R2: A ready lookup that matches a valid entry raises `look_hit` in the same cycle. `look_ra` equals {entry real page number, `look_ea[11:0]`}. `look_ra` is zero when there is no hit.
- R3: An entry matches only lookups whose thread number equals the thread tag it was filled with. An identical page number from the other thread misses.
- R4: A valid, ready lookup that matches no entry raises `mreq_valid` in the same cycle. `mreq_tid` equals `look_tid` and `mreq_epn` equals `look_ea[63:12]`. No request is raised on a hit.
- R5: After a request for thread t, `look_rdy` is low for lookups of thread t until the cycle after a fill for thread t. While not ready, a lookup neither hits nor requests. The other thread is unaffected.
- R6: A fill installs its thread, page number and real page number. A lookup in the following cycle hits it.
- R7: A fill of a new key uses the lowest-numbered empty entry if one exists. Otherwise it evicts the entry under a round-robin pointer that starts at entry 0 and advances by one, wrapping, after each eviction.
- R8: A fill whose thread and page number match an existing entry replaces that entry's real page number without allocating a new entry. At most one entry ever matches a lookup.
- R9: `inv_all` clears every entry by the next cycle.
- R10: `inv_thr_en` with `inv_thr_tid` clears only entries tagged with that thread. Entries of the other thread keep hitting.
- R11: A fill in the same cycle as `inv_all`, or as a per-thread invalidate of the fill's own thread, is discarded, but it still ends that thread's wait. A per-thread invalidate of the other thread does not discard the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| look_valid | input | 1 | Lookup request |
| look_tid | input | 1 | Thread number of the lookup |
| look_ea | input | 64 | Effective address to translate |
| look_rdy | output | 1 | Lookup thread has no outstanding miss |
| look_hit | output | 1 | Translation found this cycle |
| look_ra | output | 50 | Real address on hit, else zero |
| mreq_valid | output | 1 | Miss request to the second level |
| mreq_tid | output | 1 | Thread of the miss request |
| mreq_epn | output | 52 | Effective page number that missed |
| fill_valid | input | 1 | Second-level answer present |
| fill_tid | input | 1 | Thread of the answer |
| fill_epn | input | 52 | Effective page number of the answer |
| fill_rpn | input | 38 | Real page number of the answer |
| inv_all | input | 1 | Invalidate every entry |
| inv_thr_en | input | 1 | Invalidate one thread's entries |
| inv_thr_tid | input | 1 | Thread whose entries are invalidated |

## Verification
The lookup path is driven with a vector table in which the same page number is installed for both threads with different real pages, and page offsets from zero to all-ones are used. Correct thread separation and offset pass-through are therefore distinguished from a tag compare that ignores the thread, or from offset bits taken from the table. Sequential fills past capacity separate lowest-free placement from round-robin eviction, and show which entry a wrong pointer start or a wrong advance would lose. A refill of a present key, with the table full, separates in-place update from a fresh allocation. Fills that coincide with each kind of invalidate separate a correct discard, and a correct release of the waiting thread, from a fill that is wrongly kept or a thread left stalled.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    localparam int EA_W     = 64;
    localparam int RA_W     = 50;
    localparam int PG_OFS_W = 12;
    localparam int EPN_W    = EA_W - PG_OFS_W;
    localparam int RPN_W    = RA_W - PG_OFS_W;
    localparam int THREADS  = 2;
    localparam int TID_W    = $clog2(THREADS);

    typedef logic [EPN_W-1:0] epn_t;
    typedef logic [RPN_W-1:0] rpn_t;
    typedef logic [TID_W-1:0] tid_t;

    typedef struct packed {
        tid_t tid;
        epn_t epn;
    } xlt_key_t;

    typedef struct packed {
        logic vld;
        tid_t tid;
        epn_t epn;
        rpn_t rpn;
    } xlt_entry_t;

    function automatic epn_t ea_page(input logic [EA_W-1:0] ea);
        return ea[EA_W-1:PG_OFS_W];
    endfunction

    function automatic logic [RA_W-1:0] make_ra(input rpn_t rpn, input logic [EA_W-1:0] ea);
        return {rpn, ea[PG_OFS_W-1:0]};
    endfunction
endpackage

// File: rtl/xlt_match_array.sv
module xlt_match_array
    import xlt_pkg::*;
#(
    parameter int ENTRIES = 128
) (
    input  xlt_entry_t [ENTRIES-1:0] ents,
    input  xlt_key_t                 key,
    output logic [ENTRIES-1:0]       hit_vec,
    output rpn_t                     hit_rpn
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = ents[i].vld && (ents[i].tid == key.tid) && (ents[i].epn == key.epn);
    end

    always_comb begin
        hit_rpn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_rpn = hit_rpn | ents[i].rpn;
        end
    end
endmodule

// File: rtl/xlt_victim_sel.sv
module xlt_victim_sel #(
    parameter int ENTRIES = 128,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               alloc,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] first_free;
    logic             has_free;

    always_comb begin
        first_free = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) first_free = IDX_W'(i);
        end
    end

    assign has_free = ~&valid_vec;
    assign victim   = has_free ? first_free : rr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (alloc && !has_free) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/xlt_miss_track.sv
module xlt_miss_track
    import xlt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  tid_t               set_tid,
    input  logic               clr_en,
    input  tid_t               clr_tid,
    output logic [THREADS-1:0] pend
);
    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[t] <= 1'b0;
            end else if (set_en && set_tid == tid_t'(t)) begin
                pend[t] <= 1'b1;
            end else if (clr_en && clr_tid == tid_t'(t)) begin
                pend[t] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/xlt_l1_table.sv
module xlt_l1_table
    import xlt_pkg::*;
#(
    parameter int ENTRIES = 128,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             look_valid,
    input  logic [TID_W-1:0] look_tid,
    input  logic [EA_W-1:0]  look_ea,
    output logic             look_rdy,
    output logic             look_hit,
    output logic [RA_W-1:0]  look_ra,
    output logic             mreq_valid,
    output logic [TID_W-1:0] mreq_tid,
    output logic [EPN_W-1:0] mreq_epn,
    input  logic             fill_valid,
    input  logic [TID_W-1:0] fill_tid,
    input  logic [EPN_W-1:0] fill_epn,
    input  logic [RPN_W-1:0] fill_rpn,
    input  logic             inv_all,
    input  logic             inv_thr_en,
    input  logic [TID_W-1:0] inv_thr_tid
);
    xlt_entry_t [ENTRIES-1:0] ent_q;
    logic [ENTRIES-1:0]       valid_vec;
    logic [ENTRIES-1:0]       look_hit_vec;
    logic [ENTRIES-1:0]       fill_hit_vec;
    logic [THREADS-1:0]       pend_vec;
    logic [IDX_W-1:0]         victim;
    rpn_t                     look_rpn;
    rpn_t                     fill_old_rpn;
    xlt_key_t                 look_key;
    xlt_key_t                 fill_key;
    logic                     any_look_hit;
    logic                     refresh;
    logic                     fill_drop;
    logic                     fill_take;
    logic                     alloc;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_vld
        assign valid_vec[i] = ent_q[i].vld;
    end

    assign look_key = '{tid: look_tid, epn: ea_page(look_ea)};
    assign fill_key = '{tid: fill_tid, epn: fill_epn};

    xlt_match_array #(.ENTRIES(ENTRIES)) u_look_cmp (
        .ents    (ent_q),
        .key     (look_key),
        .hit_vec (look_hit_vec),
        .hit_rpn (look_rpn)
    );

    xlt_match_array #(.ENTRIES(ENTRIES)) u_fill_cmp (
        .ents    (ent_q),
        .key     (fill_key),
        .hit_vec (fill_hit_vec),
        .hit_rpn (fill_old_rpn)
    );

    assign any_look_hit = |look_hit_vec;
    assign look_rdy     = !pend_vec[look_tid];
    assign look_hit     = look_valid && look_rdy && any_look_hit;
    assign look_ra      = look_hit ? make_ra(look_rpn, look_ea) : '0;
    assign mreq_valid   = look_valid && look_rdy && !any_look_hit;
    assign mreq_tid     = look_tid;
    assign mreq_epn     = ea_page(look_ea);

    assign fill_drop = inv_all || (inv_thr_en && (inv_thr_tid == fill_tid));
    assign fill_take = fill_valid && !fill_drop;
    assign refresh   = |fill_hit_vec;
    assign alloc     = fill_take && !refresh;

    xlt_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (valid_vec),
        .alloc     (alloc),
        .victim    (victim)
    );

    xlt_miss_track u_miss (
        .clk     (clk),
        .rst     (rst),
        .set_en  (mreq_valid),
        .set_tid (look_tid),
        .clr_en  (fill_valid),
        .clr_tid (fill_tid),
        .pend    (pend_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (inv_all) begin
                    ent_q[i].vld <= 1'b0;
                end else if (inv_thr_en && ent_q[i].tid == inv_thr_tid) begin
                    ent_q[i].vld <= 1'b0;
                end
                if (fill_take && refresh && fill_hit_vec[i]) begin
                    ent_q[i].rpn <= fill_rpn;
                end else if (alloc && victim == IDX_W'(i)) begin
                    ent_q[i] <= '{vld: 1'b1, tid: fill_tid, epn: fill_epn, rpn: fill_rpn};
                end
            end
        end
    end
endmodule

// File: rtl/xlt_l1_table_chk.sv
module xlt_l1_table_chk
    import xlt_pkg::*;
#(
    parameter int ENTRIES = 128
) (
    input logic               clk,
    input logic               rst,
    input logic [ENTRIES-1:0] look_hit_vec,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [THREADS-1:0] pend_vec,
    input logic               mreq_valid,
    input logic [TID_W-1:0]   mreq_tid,
    input logic               fill_valid,
    input logic [TID_W-1:0]   fill_tid,
    input logic               inv_all
);
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_vec == '0 && pend_vec == '0)); // R1

    AST_REQ_ONLY_MISS: assert property (@(posedge clk) disable iff (rst)
        mreq_valid |-> (look_hit_vec == '0)); // R4

    AST_REQ_SETS_WAIT: assert property (@(posedge clk) disable iff (rst)
        mreq_valid |=> pend_vec[$past(mreq_tid)]); // R5

    AST_FILL_ENDS_WAIT: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !(mreq_valid && mreq_tid == fill_tid)) |=> !pend_vec[$past(fill_tid)]); // R11

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(look_hit_vec)); // R8

    AST_INV_ALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (valid_vec == '0)); // R9
endmodule

bind xlt_l1_table xlt_l1_table_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .look_hit_vec (look_hit_vec),
    .valid_vec    (valid_vec),
    .pend_vec     (pend_vec),
    .mreq_valid   (mreq_valid),
    .mreq_tid     (mreq_tid),
    .fill_valid   (fill_valid),
    .fill_tid     (fill_tid),
    .inv_all      (inv_all)
);

// File: tb/xlt_l1_table_tb.sv
`timescale 1ns/1ps
module xlt_l1_table_tb_top;
    localparam int NE = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        look_valid = 1'b0;
    logic        look_tid = 1'b0;
    logic [63:0] look_ea = '0;
    logic        look_rdy, look_hit, mreq_valid, mreq_tid;
    logic [49:0] look_ra;
    logic [51:0] mreq_epn;
    logic        fill_valid = 1'b0;
    logic        fill_tid = 1'b0;
    logic [51:0] fill_epn = '0;
    logic [37:0] fill_rpn = '0;
    logic        inv_all = 1'b0;
    logic        inv_thr_en = 1'b0;
    logic        inv_thr_tid = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xlt_l1_table #(.ENTRIES(NE)) dut_i (
        .clk(clk), .rst(rst),
        .look_valid(look_valid), .look_tid(look_tid), .look_ea(look_ea),
        .look_rdy(look_rdy), .look_hit(look_hit), .look_ra(look_ra),
        .mreq_valid(mreq_valid), .mreq_tid(mreq_tid), .mreq_epn(mreq_epn),
        .fill_valid(fill_valid), .fill_tid(fill_tid), .fill_epn(fill_epn), .fill_rpn(fill_rpn),
        .inv_all(inv_all), .inv_thr_en(inv_thr_en), .inv_thr_tid(inv_thr_tid)
    );

    typedef struct packed {
        logic       tid;
        logic [7:0] pg;
        logic [11:0] ofs;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{tid: 1'b0, pg: 8'd0, ofs: 12'h000},
        '{tid: 1'b1, pg: 8'd0, ofs: 12'hFFF},
        '{tid: 1'b0, pg: 8'd2, ofs: 12'h123},
        '{tid: 1'b0, pg: 8'd1, ofs: 12'h800},
        '{tid: 1'b1, pg: 8'd0, ofs: 12'h001},
        '{tid: 1'b0, pg: 8'd0, ofs: 12'hABC}
    };

    function automatic logic [51:0] epn_of(input int k);
        return 52'hC_0000_0000 + 52'(k);
    endfunction

    function automatic logic [37:0] rpn_of(input logic t, input int k, input int g);
        return 38'h1000 + 38'(k) + 38'(t) * 38'd256 + 38'(g) * 38'h10000;
    endfunction

    function automatic logic [63:0] ea_of(input int k, input logic [11:0] ofs);
        return {epn_of(k), ofs};
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // lookup, compared in the same cycle before the clock edge
    task automatic look(input string req, input logic t, input logic [63:0] ea,
                        input logic e_rdy, input logic e_hit, input logic [49:0] e_ra, input logic e_req);
        @(negedge clk);
        look_valid = 1'b1; look_tid = t; look_ea = ea;
        #1;
        chk(req, "rdy", 64'(look_rdy), 64'(e_rdy));
        chk(req, "hit", 64'(look_hit), 64'(e_hit));
        chk(req, "ra", 64'(look_ra), 64'(e_ra));
        chk(req, "req", 64'(mreq_valid), 64'(e_req));
        if (e_req) begin
            chk(req, "req_tid", 64'(mreq_tid), 64'(t));
            chk(req, "req_epn", 64'(mreq_epn), 64'(ea[63:12]));
        end
        @(posedge clk);
        #1 look_valid = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic t, input int k, input int g);
        look(req, t, ea_of(k, 12'h5A5), 1'b1, 1'b1, {rpn_of(t, k, g), 12'h5A5}, 1'b0);
    endtask

    task automatic expect_miss(input string req, input logic t, input int k);
        look(req, t, ea_of(k, 12'h0F0), 1'b1, 1'b0, 50'h0, 1'b1);
    endtask

    task automatic fill(input logic t, input int k, input int g,
                        input logic ia, input logic it_en, input logic it);
        @(negedge clk);
        fill_valid = 1'b1; fill_tid = t; fill_epn = epn_of(k); fill_rpn = rpn_of(t, k, g);
        inv_all = ia; inv_thr_en = it_en; inv_thr_tid = it;
        @(posedge clk);
        #1;
        fill_valid = 1'b0; inv_all = 1'b0; inv_thr_en = 1'b0;
    endtask

    task automatic inval(input logic ia, input logic it_en, input logic it);
        @(negedge clk);
        inv_all = ia; inv_thr_en = it_en; inv_thr_tid = it;
        @(posedge clk);
        #1;
        inv_all = 1'b0; inv_thr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: empty after reset; R4 request fields; R5 per-thread wait
        expect_miss("R1", 1'b0, 3);
        look("R5", 1'b0, ea_of(3, 12'h0), 1'b0, 1'b0, 50'h0, 1'b0);
        expect_miss("R5", 1'b1, 4);
        fill(1'b1, 4, 0, 1'b0, 1'b0, 1'b0);
        look("R5", 1'b0, ea_of(3, 12'h0), 1'b0, 1'b0, 50'h0, 1'b0);
        expect_hit("R6", 1'b1, 4, 0);
        fill(1'b0, 3, 0, 1'b0, 1'b0, 1'b0);
        expect_hit("R6", 1'b0, 3, 0);

        // vector table: R2 offsets, R3 thread separation
        do_reset();
        fill(1'b0, 0, 0, 1'b0, 1'b0, 1'b0);
        fill(1'b0, 1, 0, 1'b0, 1'b0, 1'b0);
        fill(1'b0, 2, 0, 1'b0, 1'b0, 1'b0);
        fill(1'b1, 0, 0, 1'b0, 1'b0, 1'b0);
        for (int v = 0; v < 6; v++) begin
            look("R2", VEC[v].tid, ea_of(int'(VEC[v].pg), VEC[v].ofs), 1'b1, 1'b1,
                 {rpn_of(VEC[v].tid, int'(VEC[v].pg), 0), VEC[v].ofs}, 1'b0);
        end
        expect_miss("R3", 1'b1, 2);
        look("R5", 1'b1, ea_of(0, 12'h0), 1'b0, 1'b0, 50'h0, 1'b0);
        fill(1'b1, 2, 0, 1'b0, 1'b0, 1'b0);
        expect_hit("R3", 1'b1, 2, 0);
        expect_hit("R3", 1'b0, 2, 0);

        // R7: free entries first, then round-robin eviction from entry 0
        do_reset();
        for (int k = 0; k < NE; k++) fill(1'b0, k, 0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < NE; k++) expect_hit("R7", 1'b0, k, 0);
        fill(1'b0, NE, 0, 1'b0, 1'b0, 1'b0);
        for (int k = 1; k <= NE; k++) expect_hit("R7", 1'b0, k, 0);
        fill(1'b0, NE + 1, 0, 1'b0, 1'b0, 1'b0);
        for (int k = 2; k <= NE + 1; k++) expect_hit("R7", 1'b0, k, 0);
        expect_miss("R7", 1'b0, 0);
        fill(1'b0, 0, 0, 1'b0, 1'b0, 1'b0);
        expect_miss("R7", 1'b0, 1);

        // R10 per-thread invalidate, R7 reuse of freed slots, R8 refresh
        do_reset();
        fill(1'b1, 0, 0, 1'b0, 1'b0, 1'b0);
        fill(1'b1, 1, 0, 1'b0, 1'b0, 1'b0);
        for (int k = 10; k < 10 + NE - 2; k++) fill(1'b0, k, 0, 1'b0, 1'b0, 1'b0);
        inval(1'b0, 1'b1, 1'b1);
        for (int k = 10; k < 10 + NE - 2; k++) expect_hit("R10", 1'b0, k, 0);
        expect_miss("R10", 1'b1, 0);
        fill(1'b1, 20, 0, 1'b0, 1'b0, 1'b0);
        for (int k = 10; k < 10 + NE - 2; k++) expect_hit("R7", 1'b0, k, 0);
        expect_hit("R7", 1'b1, 20, 0);
        fill(1'b1, 21, 0, 1'b0, 1'b0, 1'b0);
        fill(1'b0, 10, 1, 1'b0, 1'b0, 1'b0);
        expect_hit("R8", 1'b0, 10, 1);
        for (int k = 11; k < 10 + NE - 2; k++) expect_hit("R8", 1'b0, k, 0);
        expect_hit("R8", 1'b1, 20, 0);
        expect_hit("R8", 1'b1, 21, 0);

        // R9 invalidate-all
        inval(1'b1, 1'b0, 1'b0);
        expect_miss("R9", 1'b0, 11);
        expect_miss("R9", 1'b1, 20);

        // R11 fill discarded by a coinciding invalidate but wait released
        fill(1'b0, 11, 0, 1'b1, 1'b0, 1'b0);
        expect_miss("R11", 1'b0, 11);
        fill(1'b1, 20, 0, 1'b0, 1'b1, 1'b1);
        expect_miss("R11", 1'b1, 20);
        fill(1'b0, 11, 0, 1'b0, 1'b1, 1'b1);
        expect_hit("R11", 1'b0, 11, 0);
        look("R5", 1'b1, ea_of(20, 12'h0), 1'b0, 1'b0, 50'h0, 1'b0);

        finish_run();
    end
endmodule